// File: doc/BRIEF.md
# Boot Strap Latch and Low-Address Remapper

This block decides, shortly after reset, which physical memory answers at address zero. Two strap inputs are captured on one fixed rising clock edge after reset is released. The captured value is held and picks one of three targets: main flash, the system (loader) memory or SRAM. Any bus address inside the low alias window is rebased onto the chosen memory. All other addresses, including each memory's own home range, pass through untouched. Each memory can therefore be reached both at zero and at its own base.

A core that boots from this map reads its initial stack pointer from word 0x0 and its first code address from word 0x4. Both words land at the chosen memory's base and base+4. Until the straps have been captured, `boot_valid` stays low so that fetches are held off. When the system leaves standby, a pulse on `standby_exit` restarts the capture window and the straps are captured again.

Top module: `boot_alias_map`

## Requirements
- R1: While `rst_n` is low, `boot_valid` is 0 and `boot_sel` is 2'b00.
- R2: `boot_valid` goes to 1 on exactly the SAMPLE_EDGE-th (default 4th) rising clock edge after `rst_n` is released, and is 0 after every earlier edge.
- R3: `boot_sel` reflects the straps as they stand at the capturing edge. Strap changes before or after that edge have no effect on `boot_sel` while `boot_valid` stays 1.
- R4: Strap decoding to `boot_sel` is as follows. `strap_alt`=0 gives 2'b00 (flash), whatever `strap_ram` is. `strap_alt`=1 with `strap_ram`=0 gives 2'b01 (system memory). `strap_alt`=1 with `strap_ram`=1 gives 2'b10 (SRAM). The value 2'b11 never appears.
- R5: When `bus_addr` is below 2**ALIAS_W (default 0x0008_0000), `alias_hit` is 1 in the same cycle. In that case `phys_addr` equals the base of the memory named by `boot_sel` plus `bus_addr[ALIAS_W-1:0]`. The bases are FLASH_BASE 0x0800_0000, SYSMEM_BASE 0x1FFF_F000 and SRAM_BASE 0x2000_0000. Words 0x0 and 0x4 thus map to base and base+4.
- R6: When `bus_addr` is 2**ALIAS_W or above, `alias_hit` is 0 and `phys_addr` equals `bus_addr`. This covers each memory's own home range.
- R7: A rising edge with `standby_exit` high drives `boot_valid` to 0 after that edge. `boot_sel` keeps its previous value until the straps are captured again. That capture happens on the SAMPLE_EDGE-th rising edge after the `standby_exit` edge, and `boot_valid` returns to 1 on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_exit | input | 1 | One-cycle pulse marking the exit from standby |
| strap_alt | input | 1 | Strap pin: 0 forces flash boot |
| strap_ram | input | 1 | Strap pin: picks SRAM over system memory when `strap_alt` is 1 |
| bus_addr | input | ADDR_W | Incoming bus address |
| boot_valid | output | 1 | Straps captured; fetching may begin |
| boot_sel | output | 2 | Latched boot target (00 flash, 01 system memory, 10 SRAM) |
| alias_hit | output | 1 | `bus_addr` lies in the low alias window |
| phys_addr | output | ADDR_W | Translated physical address |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 19-bit alias window and a capture on the fourth edge. With these values, random addresses biased toward the low region hit both sides of the 0x7FFFF/0x80000 boundary often. The short four-edge window lets the bench toggle the straps between single edges, so that only the value present at the capturing edge can explain the result. Standby exits are issued both when the block is idle and in the middle of a capture window. This exercises both restart paths.

// File: rtl/boot_alias_map.sv
module boot_alias_map #(
  parameter int ADDR_W      = 32,
  parameter int ALIAS_W     = 19,
  parameter int SAMPLE_EDGE = 4,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] SYSMEM_BASE = 32'h1FFF_F000,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_exit,
  input  logic              strap_alt,
  input  logic              strap_ram,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              boot_valid,
  output logic [1:0]        boot_sel,
  output logic              alias_hit,
  output logic [ADDR_W-1:0] phys_addr
);

  localparam int CW = (SAMPLE_EDGE > 1) ? $clog2(SAMPLE_EDGE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_EDGE - 1);

  logic [CW-1:0]     edge_cnt;
  logic [1:0]        strap_mode;
  logic [ADDR_W-1:0] sel_base;

  assign strap_mode = !strap_alt ? 2'b00 : (strap_ram ? 2'b10 : 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt   <= '0;
      boot_valid <= 1'b0;
      boot_sel   <= 2'b00;
    end else if (standby_exit) begin
      edge_cnt   <= '0;
      boot_valid <= 1'b0;
    end else if (!boot_valid) begin
      if (edge_cnt == LAST) begin
        boot_valid <= 1'b1;
        boot_sel   <= strap_mode;
      end else begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (boot_sel)
      2'b01:   sel_base = SYSMEM_BASE;
      2'b10:   sel_base = SRAM_BASE;
      default: sel_base = FLASH_BASE;
    endcase
  end

  assign alias_hit = (bus_addr[ADDR_W-1:ALIAS_W] == '0);
  assign phys_addr = alias_hit
                   ? sel_base + {{(ADDR_W-ALIAS_W){1'b0}}, bus_addr[ALIAS_W-1:0]}
                   : bus_addr;

endmodule

// File: rtl/boot_alias_map_chk.sv
module boot_alias_map_chk #(
  parameter int ADDR_W      = 32,
  parameter int ALIAS_W     = 19,
  parameter int SAMPLE_EDGE = 4,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] SYSMEM_BASE = 32'h1FFF_F000,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h2000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby_exit,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              boot_valid,
  input logic [1:0]        boot_sel,
  input logic              alias_hit,
  input logic [ADDR_W-1:0] phys_addr
);

  localparam int WW = $clog2(SAMPLE_EDGE + 2);
  localparam logic [WW-1:0] WMAX = WW'(SAMPLE_EDGE + 1);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(1) << ALIAS_W;

  logic [WW-1:0]     win;
  logic [ADDR_W-1:0] exp_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            win <= '0;
    else if (standby_exit) win <= '0;
    else if (win != WMAX)  win <= win + 1'b1;
  end

  always_comb begin
    case (boot_sel)
      2'b01:   exp_base = SYSMEM_BASE;
      2'b10:   exp_base = SRAM_BASE;
      default: exp_base = FLASH_BASE;
    endcase
  end

  a_r2_valid_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_valid) |-> (win == WW'(SAMPLE_EDGE)));

  a_r3_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_valid && $past(boot_valid)) |-> $stable(boot_sel));

  a_r4_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    boot_sel != 2'b11);

  a_r5_alias_range: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < SPAN) |-> (alias_hit && ((phys_addr - exp_base) < SPAN)));

  a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= SPAN) |-> (!alias_hit && phys_addr == bus_addr));

  a_r7_standby_drop: assert property (@(posedge clk) disable iff (!rst_n)
    standby_exit |=> !boot_valid);

endmodule

bind boot_alias_map boot_alias_map_chk #(
  .ADDR_W(ADDR_W), .ALIAS_W(ALIAS_W), .SAMPLE_EDGE(SAMPLE_EDGE),
  .FLASH_BASE(FLASH_BASE), .SYSMEM_BASE(SYSMEM_BASE), .SRAM_BASE(SRAM_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .standby_exit(standby_exit), .bus_addr(bus_addr),
  .boot_valid(boot_valid), .boot_sel(boot_sel), .alias_hit(alias_hit),
  .phys_addr(phys_addr)
);

// File: tb/boot_alias_map_tb.sv
module boot_alias_map_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby_exit = 1'b0;
  logic        strap_alt = 1'b0;
  logic        strap_ram = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        boot_valid;
  logic [1:0]  boot_sel;
  logic        alias_hit;
  logic [31:0] phys_addr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  boot_alias_map u_dut (
    .clk(clk), .rst_n(rst_n), .standby_exit(standby_exit),
    .strap_alt(strap_alt), .strap_ram(strap_ram), .bus_addr(bus_addr),
    .boot_valid(boot_valid), .boot_sel(boot_sel), .alias_hit(alias_hit),
    .phys_addr(phys_addr)
  );

  function automatic logic [1:0] exp_sel(input logic alt, input logic ram);
    return !alt ? 2'b00 : (ram ? 2'b10 : 2'b01);
  endfunction

  function automatic logic [31:0] exp_phys(input logic [1:0] s, input logic [31:0] a);
    logic [31:0] b;
    if (a >= 32'h0008_0000) return a;
    b = (s == 2'b01) ? 32'h1FFF_F000 : (s == 2'b10) ? 32'h2000_0000 : 32'h0800_0000;
    return b + a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_straps(input logic alt, input logic ram);
    strap_alt = alt;
    strap_ram = ram;
  endtask

  task automatic chk_addr(input logic [31:0] a, input logic [1:0] s);
    bus_addr = a;
    #1;
    chk("R5/R6 phys_addr", phys_addr, exp_phys(s, a));
    chk("R5/R6 alias_hit", {31'b0, alias_hit}, {31'b0, a < 32'h0008_0000});
  endtask

  task automatic capture_window(input logic alt, input logic ram);
    for (int e = 1; e <= 3; e++) begin
      set_straps(~alt, ~ram);
      tick();
      chk("R2 valid low before 4th edge", {31'b0, boot_valid}, 32'd0);
    end
    set_straps(alt, ram);
    tick();
    chk("R2 valid at 4th edge", {31'b0, boot_valid}, 32'd1);
    chk("R3/R4 captured sel", {30'b0, boot_sel}, {30'b0, exp_sel(alt, ram)});
    set_straps(~alt, ~ram);
    tick(); tick();
    chk("R3 straps ignored after capture", {30'b0, boot_sel}, {30'b0, exp_sel(alt, ram)});
  endtask

  initial begin
    void'($urandom(32'd1234));
    set_straps(1'b1, 1'b1);
    tick(); tick();
    chk("R1 reset valid", {31'b0, boot_valid}, 32'd0);
    chk("R1 reset sel", {30'b0, boot_sel}, 32'd0);
    rst_n = 1'b1;
    capture_window(1'b1, 1'b0);
    chk_addr(32'h0, 2'b01);
    chk_addr(32'h4, 2'b01);
    chk_addr(32'h0007_FFFF, 2'b01);
    chk_addr(32'h0008_0000, 2'b01);
    chk_addr(32'h1FFF_F000, 2'b01);

    for (int m = 0; m < 4; m++) begin
      logic a, r;
      logic [1:0] prev;
      a = m[1]; r = m[0];
      prev = boot_sel;
      standby_exit = 1'b1;
      tick();
      standby_exit = 1'b0;
      chk("R7 valid drops", {31'b0, boot_valid}, 32'd0);
      chk("R7 sel held", {30'b0, boot_sel}, {30'b0, prev});
      capture_window(a, r);
      for (int k = 0; k < 50; k++) begin
        logic [31:0] ad;
        ad = ($urandom % 2) ? ($urandom % 32'h0010_0000) : $urandom;
        chk_addr(ad, exp_sel(a, r));
      end
    end

    tick();
    standby_exit = 1'b1;
    tick();
    standby_exit = 1'b0;
    tick();
    standby_exit = 1'b1;
    tick();
    standby_exit = 1'b0;
    chk("R7 restart mid-window", {31'b0, boot_valid}, 32'd0);
    capture_window(1'b0, 1'b1);
    chk_addr(32'h0000_0004, 2'b00);

    rst_n = 1'b0;
    #1;
    chk("R1 async reset valid", {31'b0, boot_valid}, 32'd0);
    chk("R1 async reset sel", {30'b0, boot_sel}, 32'd0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule